// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs one external memory access at a time on a 16-bit bus whose lines carry the address first and the data afterwards. An internal master hands it a request: address, write data, direction, and whether one byte or a whole word is moved. The block then runs an address phase of one clock and a data phase of one clock or more, drives the strobes that external latches, decoders and memories need, and returns the read data with a one-clock completion pulse.

Static configuration inputs choose how the strobes look, how wide the bus is and how many wait states READY may add. One bit picks between a short latch pulse and an address-valid level that spans the whole cycle. A second bit picks between two separate write strobes per byte lane and a single write strobe with a byte-high enable. The bus width can be fixed, or it can follow an input pin that is sampled when each request is accepted. A low READY adds wait clocks up to a programmed cap, and the cap can also be unlimited.

Top module: `xbus_cycle_ctrl`

## Requirements
- R1: Out of reset and whenever no cycle is running, `ale`, `ad_oe`, `done` and `ad_out` are 0, and `adv_n`, `rd_n`, `wstb_lo_n` and `wstb_hi_n` are 1.
- R2: A request seen with `req_valid` high while idle starts an address phase on the next clock. That phase lasts one clock, with `ad_oe`=1 and `ad_out`=address. If `cfg_mode[1]`=1, `ale` is high only in that clock. If `cfg_mode[1]`=0, `adv_n` is low through the address and data phases and high again in the `done` clock.
- R3: When `cfg_mode[0]`=1, `wstb_lo_n` is low in every clock of a write data phase. `wstb_hi_n` works as a byte-high enable: it is low through the address and data phases of a 16-bit cycle that moves a word or uses an odd address, and high otherwise.
- R4: When `cfg_mode[0]`=0, both pins are write strobes and are low only during a write data phase. In 16-bit cycles `wstb_lo_n` asserts for word writes and even-address byte writes, and `wstb_hi_n` asserts for word writes and odd-address byte writes. In 8-bit cycles both assert on every write.
- R5: `rd_n` is low only in the data phase of a read. During that phase `ad_oe` is 0. No write strobe asserts in a read.
- R6: `cfg_width` = 01 gives a 16-bit bus and 10 gives an 8-bit bus. With 11, `width_sel` decides (1 = 16-bit, 0 = 8-bit). The width is taken when the request is accepted.
- R7: `cfg_wait` sets the cap on READY wait clocks: 000 = 0, 100 = 1, 101 = 2, 110 = 3. The data phase lasts 1 + min(low READY samples, cap) clocks, so done appears 3 + waits clocks after the request clock.
- R8: With `cfg_wait` = 111 the data phase continues as long as READY is sampled low, without limit.
- R9: `config_error` is high, combinationally, while `cfg_width` = 00 or `cfg_wait` is 001, 010 or 011. Such a cycle runs as 16-bit with no wait states.
- R10: `rd_data` is loaded from `ad_in` in the last data clock of a read and holds until the next read completes. A 16-bit word read gives `ad_in`. A 16-bit odd-address byte read gives zero-extended `ad_in[15:8]`. Every other read gives zero-extended `ad_in[7:0]`.
- R11: In a write data phase `ad_out` carries `req_wdata` for a 16-bit word write. For every other write it carries `req_wdata[7:0]` on both byte lanes.
- R12: `done` is high for exactly one clock per cycle, in the clock after the last data clock. A request that arrives while a cycle is running is ignored. A request in the `done` clock is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start a cycle (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_addr | input | 16 | Access address; bit 0 selects the byte lane |
| req_wdata | input | 16 | Write data |
| cfg_mode | input | 2 | [1] latch pulse vs address-valid, [0] single write+byte-high vs split writes |
| cfg_width | input | 2 | Bus width code |
| cfg_wait | input | 3 | Wait-cap code |
| width_sel | input | 1 | Width choice when cfg_width = 11 |
| ready | input | 1 | Low stretches the data phase |
| ad_in | input | 16 | Bus lines as seen from outside |
| ad_out | output | 16 | Value driven onto the bus lines |
| ad_oe | output | 1 | Bus output enable |
| ale | output | 1 | Address latch pulse, active high |
| adv_n | output | 1 | Address valid, active low |
| rd_n | output | 1 | Read strobe, active low |
| wstb_lo_n | output | 1 | Low write strobe or single write strobe |
| wstb_hi_n | output | 1 | High write strobe or byte-high enable |
| rd_data | output | 16 | Read result |
| done | output | 1 | One-clock completion pulse |
| config_error | output | 1 | Illegal width or wait code present |

## Verification
On every clock the assertions check the parts of the protocol that hold in any cycle. The latch pulse never lasts two clocks and never coincides with address-valid. The bus is never driven while the read strobe is low. The read strobe only falls after a driven address phase. `done` never repeats on consecutive clocks. Behaviour that depends on the configuration codes and the request has to come from the bench scenarios, which compare every output against a reference model on each clock. These include the lane chosen for read data, which write strobe fires for each width and size, how long a data phase runs for each cap and READY pattern, the unlimited cap, and the fallback for illegal codes.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    // Phase of the external cycle
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    // Position of the mode bits inside cfg_mode
    localparam int MODE_LATCH_BIT  = 1;
    localparam int MODE_SINGLE_BIT = 0;

    // Largest finite wait cap is 3, so two bits hold it
    localparam int WAIT_CAP_MAX = 3;
    localparam int LIM_W        = $clog2(WAIT_CAP_MAX + 1);

    localparam int BYTE_W = 8;
endpackage

// File: rtl/xbus_cfg_decode.sv
module xbus_cfg_decode
    import xbus_pkg::*;
(
    input  logic [1:0]       width_code,
    input  logic [2:0]       wait_code,
    input  logic             width_pin,
    output logic             wide,
    output logic [LIM_W-1:0] limit,
    output logic             unlimited,
    output logic             illegal
);
    logic bad_width;
    logic bad_wait;

    always_comb begin
        bad_width = 1'b0;
        case (width_code)
            2'b01:   wide = 1'b1;
            2'b10:   wide = 1'b0;
            2'b11:   wide = width_pin;
            default: begin
                wide      = 1'b1;
                bad_width = 1'b1;
            end
        endcase
    end

    always_comb begin
        bad_wait  = 1'b0;
        unlimited = 1'b0;
        limit     = '0;
        case (wait_code)
            3'b000: limit = LIM_W'(0);
            3'b100: limit = LIM_W'(1);
            3'b101: limit = LIM_W'(2);
            3'b110: limit = LIM_W'(3);
            3'b111: unlimited = 1'b1;
            default: bad_wait = 1'b1;
        endcase
    end

    assign illegal = bad_width | bad_wait;
endmodule

// File: rtl/xbus_lane_fmt.sv
module xbus_lane_fmt
    import xbus_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             wide,
    input  logic             word,
    input  logic             a0,
    input  logic [BUS_W-1:0] wdata,
    input  logic [BUS_W-1:0] bus_in,
    output logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] rd_result,
    output logic             lane_lo,
    output logic             lane_hi
);
    localparam int LANES = BUS_W / BYTE_W;

    logic [BUS_W-1:0] byte_rep;
    logic             full_word;

    // Replicate the low byte onto every lane for byte writes
    for (genvar g = 0; g < LANES; g++) begin : g_rep
        assign byte_rep[g*BYTE_W +: BYTE_W] = wdata[BYTE_W-1:0];
    end

    assign full_word = wide & word;
    assign lane_lo   = ~wide | word | ~a0;
    assign lane_hi   = wide & (word | a0);
    assign bus_wdata = full_word ? wdata : byte_rep;

    always_comb begin
        rd_result = '0;
        if (full_word) begin
            rd_result = bus_in;
        end else if (wide && a0) begin
            rd_result[BYTE_W-1:0] = bus_in[2*BYTE_W-1:BYTE_W];
        end else begin
            rd_result[BYTE_W-1:0] = bus_in[BYTE_W-1:0];
        end
    end
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
    import xbus_pkg::*;
(
    input  phase_e phase,
    input  logic   latch_mode,
    input  logic   single_mode,
    input  logic   is_write,
    input  logic   wide,
    input  logic   lane_lo,
    input  logic   lane_hi,
    output logic   ale,
    output logic   adv_n,
    output logic   rd_n,
    output logic   lo_n,
    output logic   hi_n,
    output logic   drive
);
    logic in_addr;
    logic in_data;
    logic active;
    logic wphase;

    assign in_addr = (phase == PH_ADDR);
    assign in_data = (phase == PH_DATA);
    assign active  = in_addr | in_data;
    assign wphase  = in_data & is_write;

    assign ale   = latch_mode & in_addr;
    assign adv_n = ~(~latch_mode & active);
    assign rd_n  = ~(in_data & ~is_write);
    assign drive = in_addr | wphase;

    always_comb begin
        if (single_mode) begin
            lo_n = ~wphase;
            hi_n = ~(active & wide & lane_hi);
        end else begin
            lo_n = ~(wphase & lane_lo);
            hi_n = ~(wphase & (lane_hi | ~wide));
        end
    end
endmodule

// File: rtl/xbus_cycle_ctrl.sv
module xbus_cycle_ctrl
    import xbus_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_word,
    input  logic [BUS_W-1:0] req_addr,
    input  logic [BUS_W-1:0] req_wdata,
    input  logic [1:0]       cfg_mode,
    input  logic [1:0]       cfg_width,
    input  logic [2:0]       cfg_wait,
    input  logic             width_sel,
    input  logic             ready,
    input  logic [BUS_W-1:0] ad_in,
    output logic [BUS_W-1:0] ad_out,
    output logic             ad_oe,
    output logic             ale,
    output logic             adv_n,
    output logic             rd_n,
    output logic             wstb_lo_n,
    output logic             wstb_hi_n,
    output logic [BUS_W-1:0] rd_data,
    output logic             done,
    output logic             config_error
);
    typedef struct packed {
        phase_e           phase;
        logic             wr;
        logic             word;
        logic [BUS_W-1:0] addr;
        logic [BUS_W-1:0] wdata;
        logic             wide;
        logic             latch;
        logic             single;
        logic             unl;
        logic [LIM_W-1:0] lim;
        logic [LIM_W-1:0] wcnt;
        logic             done;
        logic [BUS_W-1:0] rdata;
    } state_t;

    localparam state_t RESET_STATE = '{phase: PH_IDLE, default: '0};

    state_t st_d;
    state_t st_q;

    logic             cfg_wide;
    logic [LIM_W-1:0] cfg_lim;
    logic             cfg_unl;
    logic [BUS_W-1:0] fmt_wdata;
    logic [BUS_W-1:0] fmt_rdata;
    logic             lane_lo;
    logic             lane_hi;
    logic             stb_drive;
    logic             data_last;

    xbus_cfg_decode u_cfg (
        .width_code (cfg_width),
        .wait_code  (cfg_wait),
        .width_pin  (width_sel),
        .wide       (cfg_wide),
        .limit      (cfg_lim),
        .unlimited  (cfg_unl),
        .illegal    (config_error)
    );

    xbus_lane_fmt #(.BUS_W(BUS_W)) u_lane (
        .wide      (st_q.wide),
        .word      (st_q.word),
        .a0        (st_q.addr[0]),
        .wdata     (st_q.wdata),
        .bus_in    (ad_in),
        .bus_wdata (fmt_wdata),
        .rd_result (fmt_rdata),
        .lane_lo   (lane_lo),
        .lane_hi   (lane_hi)
    );

    xbus_strobe_gen u_stb (
        .phase       (st_q.phase),
        .latch_mode  (st_q.latch),
        .single_mode (st_q.single),
        .is_write    (st_q.wr),
        .wide        (st_q.wide),
        .lane_lo     (lane_lo),
        .lane_hi     (lane_hi),
        .ale         (ale),
        .adv_n       (adv_n),
        .rd_n        (rd_n),
        .lo_n        (wstb_lo_n),
        .hi_n        (wstb_hi_n),
        .drive       (stb_drive)
    );

    // The data phase ends when READY is high or the finite cap is used up
    assign data_last = ready | (~st_q.unl & (st_q.wcnt == st_q.lim));

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.phase  = PH_ADDR;
                    st_d.wr     = req_write;
                    st_d.word   = req_word;
                    st_d.addr   = req_addr;
                    st_d.wdata  = req_wdata;
                    st_d.wide   = cfg_wide;
                    st_d.latch  = cfg_mode[MODE_LATCH_BIT];
                    st_d.single = cfg_mode[MODE_SINGLE_BIT];
                    st_d.unl    = cfg_unl;
                    st_d.lim    = cfg_lim;
                    st_d.wcnt   = '0;
                end
            end
            PH_ADDR: begin
                st_d.phase = PH_DATA;
                st_d.wcnt  = '0;
            end
            PH_DATA: begin
                if (data_last) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                    if (!st_q.wr) begin
                        st_d.rdata = fmt_rdata;
                    end
                end else begin
                    st_d.wcnt = st_q.wcnt + LIM_W'(1);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ad_out = '0;
        if (st_q.phase == PH_ADDR) begin
            ad_out = st_q.addr;
        end else if (st_q.phase == PH_DATA && st_q.wr) begin
            ad_out = fmt_wdata;
        end
    end

    assign ad_oe   = stb_drive;
    assign done    = st_q.done;
    assign rd_data = st_q.rdata;
endmodule

// File: rtl/xbus_cycle_chk.sv
module xbus_cycle_chk (
    input logic clk,
    input logic rst_n,
    input logic ale,
    input logic adv_n,
    input logic rd_n,
    input logic ad_oe,
    input logic done
);
    AST_ALE_SINGLE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale); // R2

    AST_ONE_ADDR_STROBE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(ale && !adv_n)); // R2

    AST_BUS_RELEASED_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe); // R5

    AST_READ_AFTER_ADDRESS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> $past(ad_oe)); // R5

    AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12
endmodule

bind xbus_cycle_ctrl xbus_cycle_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ale   (ale),
    .adv_n (adv_n),
    .rd_n  (rd_n),
    .ad_oe (ad_oe),
    .done  (done)
);

// File: tb/xbus_cycle_ctrl_tb_top.sv
`timescale 1ns/1ps
module xbus_cycle_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  cfg_mode = 2'b11;
    logic [1:0]  cfg_width = 2'b01;
    logic [2:0]  cfg_wait = 3'b000;
    logic        width_sel = 1'b1;
    logic        ready = 1'b1;
    logic [15:0] ad_in = '0;
    logic [15:0] ad_out;
    logic        ad_oe, ale, adv_n, rd_n, wstb_lo_n, wstb_hi_n, done, config_error;
    logic [15:0] rd_data;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    xbus_cycle_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_mode(cfg_mode), .cfg_width(cfg_width), .cfg_wait(cfg_wait),
        .width_sel(width_sel), .ready(ready), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .ale(ale), .adv_n(adv_n), .rd_n(rd_n),
        .wstb_lo_n(wstb_lo_n), .wstb_hi_n(wstb_hi_n), .rd_data(rd_data),
        .done(done), .config_error(config_error)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int          m_ph = 0;      // 0 idle, 1 address, 2 data
    int          m_waits = 0;
    bit          m_wr, m_word, m_wide, m_latch, m_single, m_unl;
    int          m_cap = 0;
    logic [15:0] m_addr = '0, m_wdata = '0, m_rdata = '0;
    bit          m_done = 0;

    function automatic bit ref_wide();
        if (cfg_width == 2'b10) return 1'b0;
        if (cfg_width == 2'b11) return width_sel;
        return 1'b1;
    endfunction

    function automatic int ref_cap();   // -1 means unlimited
        case (cfg_wait)
            3'b100: return 1;
            3'b101: return 2;
            3'b110: return 3;
            3'b111: return -1;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph <= 0; m_done <= 0; m_rdata <= '0; m_waits <= 0;
        end else begin
            m_done <= 0;
            if (m_ph == 0) begin
                if (req_valid) begin
                    m_ph <= 1; m_wr <= req_write; m_word <= req_word;
                    m_addr <= req_addr; m_wdata <= req_wdata;
                    m_wide <= ref_wide(); m_latch <= cfg_mode[1];
                    m_single <= cfg_mode[0];
                    m_unl <= (ref_cap() < 0); m_cap <= ref_cap();
                end
            end else if (m_ph == 1) begin
                m_ph <= 2; m_waits <= 0;
            end else begin
                if (ready || (!m_unl && m_waits == m_cap)) begin
                    m_ph <= 0; m_done <= 1;
                    if (!m_wr) begin
                        if (m_wide && m_word) m_rdata <= ad_in;
                        else if (m_wide && m_addr[0]) m_rdata <= {8'h00, ad_in[15:8]};
                        else m_rdata <= {8'h00, ad_in[7:0]};
                    end
                end else begin
                    m_waits <= m_waits + 1;
                end
            end
        end
    end

    // Compare every output each clock, away from both edges
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            bit          act, wph, bhe;
            logic [15:0] e_out;
            act = (m_ph != 0);
            wph = (m_ph == 2) && m_wr;
            e_out = 16'h0000;
            if (m_ph == 1) e_out = m_addr;
            else if (wph) e_out = (m_wide && m_word) ? m_wdata : {m_wdata[7:0], m_wdata[7:0]};
            chk("R2 ale", ale, act && m_latch && m_ph == 1);
            chk("R2 adv_n", adv_n, !(act && !m_latch));
            chk("R5 rd_n", rd_n, !(m_ph == 2 && !m_wr));
            chk("R5 ad_oe", ad_oe, m_ph == 1 || wph);
            chk("R11 ad_out", ad_out, e_out);
            if (m_single) begin
                bhe = act && m_wide && (m_word || m_addr[0]);
                chk("R3 wstb_lo_n", wstb_lo_n, !wph);
                chk("R3 wstb_hi_n", wstb_hi_n, !bhe);
            end else begin
                chk("R4 wstb_lo_n", wstb_lo_n, !(wph && (!m_wide || m_word || !m_addr[0])));
                chk("R4 wstb_hi_n", wstb_hi_n, !(wph && (!m_wide || m_word || m_addr[0])));
            end
            chk("R10 rd_data", rd_data, m_rdata);
            chk("R12 done", done, m_done);
            chk("R9 config_error", config_error,
                cfg_width == 2'b00 || cfg_wait == 3'b001 || cfg_wait == 3'b010 || cfg_wait == 3'b011);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    // One access; lo_cnt = READY low samples wanted, exp_len = clocks until done
    task automatic run_txn(input bit wr, input bit word, input logic [15:0] addr,
                           input logic [15:0] wd, input int lo_cnt, input int exp_len,
                           input string tag);
        int n;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_word = word; req_addr = addr; req_wdata = wd;
        ready = (lo_cnt == 0);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) req_valid = 0;
            if (n == 2 + lo_cnt) ready = 1;
        end while (!done && n < 40);
        chk(tag, n, exp_len);
        ready = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk("R1 reset ad_oe", ad_oe, 0);
        chk("R1 reset strobes", {ale, adv_n, rd_n, wstb_lo_n, wstb_hi_n, done}, 6'b011110);
        chk("R1 reset ad_out", ad_out, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // Sweep modes, widths, sizes and directions
        for (int md = 0; md < 4; md++) begin
            for (int wsel = 0; wsel < 4; wsel++) begin
                for (int kind = 0; kind < 3; kind++) begin
                    for (int wr = 0; wr < 2; wr++) begin
                        int cap;
                        int lo;
                        cfg_mode = md[1:0];
                        cfg_width = (wsel == 0) ? 2'b01 : (wsel == 1) ? 2'b10 : 2'b11;
                        width_sel = (wsel == 3);
                        case ((md + kind + wr) % 4)
                            0: begin cfg_wait = 3'b000; cap = 0; end
                            1: begin cfg_wait = 3'b100; cap = 1; end
                            2: begin cfg_wait = 3'b101; cap = 2; end
                            default: begin cfg_wait = 3'b110; cap = 3; end
                        endcase
                        lo = (wsel + kind) % 5;
                        ad_in = 16'hC35A ^ 16'(md * 16'h1111 + kind);
                        run_txn(wr[0], kind == 2, (kind == 1) ? 16'h2345 : 16'h1A20,
                                16'hB7E1 + 16'(wsel), lo, 3 + ((lo < cap) ? lo : cap),
                                "R7 data phase length");
                        if (wr == 0) begin
                            logic [15:0] e;
                            bit wd16;
                            wd16 = (wsel == 0) || (wsel == 3);
                            if (wd16 && kind == 2) e = ad_in;
                            else if (wd16 && kind == 1) e = {8'h00, ad_in[15:8]};
                            else e = {8'h00, ad_in[7:0]};
                            chk("R10 R6 read lane", rd_data, e);
                        end
                    end
                end
            end
        end

        // R8: unlimited cap, READY low for 9 samples
        cfg_mode = 2'b00; cfg_width = 2'b01; cfg_wait = 3'b111;
        run_txn(0, 1, 16'h0F00, 16'h0, 9, 12, "R8 unlimited waits");

        // R9: illegal width and wait codes fall back to 16-bit, zero waits
        cfg_width = 2'b00; cfg_wait = 3'b010;
        @(negedge clk); #1;
        chk("R9 error flag", config_error, 1);
        ad_in = 16'h9E4B;
        run_txn(0, 1, 16'h0100, 16'h0, 4, 3, "R9 zero waits on illegal code");
        chk("R9 16-bit fallback", rd_data, 16'h9E4B);
        cfg_width = 2'b01; cfg_wait = 3'b011;
        @(negedge clk); #1;
        chk("R9 error on wait code", config_error, 1);
        cfg_wait = 3'b000;
        @(negedge clk); #1;
        chk("R9 error clears", config_error, 0);

        // R12: request during a cycle is ignored, request in done clock accepted
        cfg_mode = 2'b11; cfg_wait = 3'b110;
        @(negedge clk);
        req_valid = 1; req_write = 1; req_word = 1; req_addr = 16'h4440; req_wdata = 16'h1234;
        ready = 0;
        @(negedge clk);
        req_addr = 16'h5551;  // still asserted while the cycle runs
        repeat (3) @(negedge clk);
        #1;
        chk("R12 busy request ignored", ad_out, 16'h1234);
        ready = 1;
        while (!done) @(negedge clk);
        req_addr = 16'h6662; req_write = 0;  // accepted in the done clock
        @(negedge clk);
        req_valid = 0;
        #1;
        chk("R12 accept in done clock", ad_out, 16'h6662);
        chk("R2 address phase enable", ad_oe, 1);
        repeat (4) @(negedge clk);
        #1;
        chk("R1 idle after cycle", {ad_oe, rd_n, wstb_lo_n, wstb_hi_n}, 4'b0111);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule